// File: doc/BRIEF.md
# Three-Port Parallel I/O Peripheral

This block is a byte-wide peripheral that sits on a CPU I/O bus. It gives the CPU three 8-bit parallel ports, A, B and C, plus one control register. Port C is split into an upper and a lower nibble, and each nibble has its own direction. A bus access uses a 2-bit register address, active-high chip select, read and write strobes, and an 8-bit data path. A write takes effect on the clock edge where chip select and the write strobe are both high. A read is combinational and returns data only while chip select and the read strobe are both high.

Writes to the control address carry two kinds of command, and bit 7 picks the kind. With bit 7 high, the byte is a mode word. It sets the direction of port A, port B and each nibble of port C, and it clears every output latch. With bit 7 low, the byte changes one bit of the port C latch and leaves the directions as they are. Only simple level I/O is built. The strobed-mode fields of the mode word are stored, but they behave the same as simple mode. Each pin has three signals at the port side: an input, an output value and an output enable.

Top module: `pio3_port`

## Requirements
- R1: Register address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register.
- R2: A read at address 3 returns the fixed value 0xFF and never the contents of the control register.
- R3: While reset is high and on the first cycle after it, every output enable is 0 and every output latch is 0. A read of ports A, B and C then returns the pin inputs.
- R4: A control write with bit 7 = 1 sets the directions. Bit 4 sets port A, bit 3 sets port C bits 7:4, bit 1 sets port B and bit 0 sets port C bits 3:0, where 1 means input and 0 means output. Bits 6:5 and bit 2 hold mode selections that behave as simple I/O.
- R5: A control write with bit 7 = 1 clears the output latches of ports A, B and C to 0.
- R6: A control write with bit 7 = 0 writes bit 0 into the port C latch bit indexed by bits 3:1. The other seven port C bits keep their values, and bits 6:4 have no effect.
- R7: A control write with bit 7 = 0 leaves every output enable unchanged.
- R8: A write to a data port always loads that port's latch. The latch is always visible on the port's output-value pins. The output enables are all 1 for a port or C nibble set as output and all 0 for one set as input.
- R9: A read of a data port returns the pin input for each bit set as input and the latch value for each bit set as output. Port C applies this per nibble.
- R10: The read data is 0 and its valid flag is 0 unless chip select and the read strobe are both high.
- R11: A register write changes state only at a clock edge where chip select and the write strobe are both high. Nothing changes before that edge, and nothing changes when chip select is low.
- R12: The mode word 0x82 makes port B an input and makes port A and both nibbles of port C outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset |
| bus_sel | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when no read is in progress |
| bus_rdata_oe | output | 1 | High while read data is being driven |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The hardest state to reach from the ports is a port C latch that holds a mix of bits, some set by single-bit commands and some loaded whole. Every mode word wipes the latch, so that state exists only between direction changes. The stimulus therefore sets all-output directions first and then walks a chain of single-bit commands. The chain includes indices 0 and 7, a command with bits 6:4 set, and a command that repeats a value already held. After each step the bench compares the full output byte and the output enables. It also reads the mixed-nibble configurations back through the bus, which shows pins and latch side by side in a single byte.

// File: rtl/pio3_pkg.sv
package pio3_pkg;

   // register address codes
   typedef enum logic [1:0] {
      SEL_PA  = 2'b00,
      SEL_PB  = 2'b01,
      SEL_PC  = 2'b10,
      SEL_CTL = 2'b11
   } reg_sel_e;

   // control word bit positions
   localparam int CW_KIND   = 7;
   localparam int CW_AMODE  = 5;
   localparam int CW_A_DIR  = 4;
   localparam int CW_CU_DIR = 3;
   localparam int CW_BMODE  = 2;
   localparam int CW_B_DIR  = 1;
   localparam int CW_CL_DIR = 0;
   localparam int CW_BITVAL = 0;

   // stored configuration, 1 in a *_in field means input
   typedef struct packed {
      logic [1:0] ga_mode;
      logic       gb_mode;
      logic       a_in;
      logic       cu_in;
      logic       b_in;
      logic       cl_in;
   } port_cfg_t;

   localparam port_cfg_t CFG_RESET = '{ga_mode: 2'b00, gb_mode: 1'b0,
                                       a_in: 1'b1, cu_in: 1'b1,
                                       b_in: 1'b1, cl_in: 1'b1};

endpackage

// File: rtl/pio3_ctrl.sv
module pio3_ctrl
   import pio3_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_stb,
   input  reg_sel_e          addr,
   input  logic [DATA_W-1:0] wdata,
   output port_cfg_t         cfg,
   output logic              mode_ld,
   output logic              bsr_en,
   output logic [IDX_W-1:0]  bsr_idx,
   output logic              bsr_val,
   output logic              a_ld,
   output logic              b_ld,
   output logic              c_ld
);

   logic ctl_hit;

   always_comb begin
      ctl_hit = wr_stb && (addr == SEL_CTL);
      mode_ld = ctl_hit && wdata[CW_KIND];
      bsr_en  = ctl_hit && !wdata[CW_KIND];
      bsr_idx = wdata[IDX_W:1];
      bsr_val = wdata[CW_BITVAL];
      a_ld    = wr_stb && (addr == SEL_PA);
      b_ld    = wr_stb && (addr == SEL_PB);
      c_ld    = wr_stb && (addr == SEL_PC);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg <= CFG_RESET;
      end else if (mode_ld) begin
         cfg.ga_mode <= wdata[CW_AMODE+1:CW_AMODE];
         cfg.gb_mode <= wdata[CW_BMODE];
         cfg.a_in    <= wdata[CW_A_DIR];
         cfg.cu_in   <= wdata[CW_CU_DIR];
         cfg.b_in    <= wdata[CW_B_DIR];
         cfg.cl_in   <= wdata[CW_CL_DIR];
      end
   end

   // R7
   bsr_cfg_stable_chk: assert property (@(posedge clk) disable iff (rst)
      bsr_en |=> $stable(cfg));

endmodule

// File: rtl/pio3_latch.sv
module pio3_latch #(
   parameter int W        = 8,
   parameter bit HAS_BSR  = 1'b0,
   localparam int IDX_W   = $clog2(W)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             ld,
   input  logic [W-1:0]     ld_data,
   input  logic             bit_en,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             bit_val,
   output logic [W-1:0]     q
);

   logic [W-1:0] nxt;

   generate
      if (HAS_BSR) begin : g_bsr
         always_comb begin
            nxt = q;
            if (clr)         nxt = '0;
            else if (ld)     nxt = ld_data;
            else if (bit_en) nxt[bit_idx] = bit_val;
         end
      end else begin : g_plain
         always_comb begin
            nxt = q;
            if (clr)     nxt = '0;
            else if (ld) nxt = ld_data;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt;
   end

   // R5
   clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
      clr |=> (q == '0));

   // R8
   load_take_chk: assert property (@(posedge clk) disable iff (rst)
      (ld && !clr) |=> (q == $past(ld_data)));

   // R6
   single_bit_chk: assert property (@(posedge clk) disable iff (rst)
      (bit_en && !ld && !clr) |=> ($countones(q ^ $past(q)) <= 1));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr && !ld && !bit_en) |=> $stable(q));

endmodule

// File: rtl/pio3_rdsel.sv
module pio3_rdsel #(
   parameter int W = 8
) (
   input  logic [W-1:0] dir_in,
   input  logic [W-1:0] pin,
   input  logic [W-1:0] lat,
   output logic [W-1:0] dout
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign dout[i] = dir_in[i] ? pin[i] : lat[i];
   end

endmodule

// File: rtl/pio3_port.sv
module pio3_port
   import pio3_pkg::*;
#(
   parameter int          DATA_W      = 8,
   parameter int          ADDR_W      = 2,
   parameter logic [7:0]  CTRL_RD_VAL = 8'hFF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_sel,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rdata_oe,
   input  logic [DATA_W-1:0] pa_in,
   output logic [DATA_W-1:0] pa_out,
   output logic [DATA_W-1:0] pa_oe,
   input  logic [DATA_W-1:0] pb_in,
   output logic [DATA_W-1:0] pb_out,
   output logic [DATA_W-1:0] pb_oe,
   input  logic [DATA_W-1:0] pc_in,
   output logic [DATA_W-1:0] pc_out,
   output logic [DATA_W-1:0] pc_oe
);

   localparam int NIB_W = DATA_W / 2;
   localparam int IDX_W = $clog2(DATA_W);

   if (DATA_W != 8) begin : g_bad_width
      $error("pio3_port: control word layout needs DATA_W of 8");
   end
   if (ADDR_W != 2) begin : g_bad_addr
      $error("pio3_port: four registers need ADDR_W of 2");
   end

   reg_sel_e         sel;
   logic             wr_stb;
   logic             rd_stb;
   port_cfg_t        cfg;
   logic             mode_ld;
   logic             bsr_en;
   logic [IDX_W-1:0] bsr_idx;
   logic             bsr_val;
   logic             a_ld;
   logic             b_ld;
   logic             c_ld;
   logic [DATA_W-1:0] a_q;
   logic [DATA_W-1:0] b_q;
   logic [DATA_W-1:0] c_q;
   logic [DATA_W-1:0] a_dir;
   logic [DATA_W-1:0] b_dir;
   logic [DATA_W-1:0] c_dir;
   logic [DATA_W-1:0] a_rd;
   logic [DATA_W-1:0] b_rd;
   logic [DATA_W-1:0] c_rd;
   logic [DATA_W-1:0] rd_mux;

   assign sel    = reg_sel_e'(bus_addr);
   assign wr_stb = bus_sel && bus_wr;
   assign rd_stb = bus_sel && bus_rd;

   pio3_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .wr_stb  (wr_stb),
      .addr    (sel),
      .wdata   (bus_wdata),
      .cfg     (cfg),
      .mode_ld (mode_ld),
      .bsr_en  (bsr_en),
      .bsr_idx (bsr_idx),
      .bsr_val (bsr_val),
      .a_ld    (a_ld),
      .b_ld    (b_ld),
      .c_ld    (c_ld)
   );

   pio3_latch #(.W(DATA_W), .HAS_BSR(1'b0)) u_lat_a (
      .clk (clk), .rst (rst), .clr (mode_ld), .ld (a_ld), .ld_data (bus_wdata),
      .bit_en (1'b0), .bit_idx ('0), .bit_val (1'b0), .q (a_q)
   );

   pio3_latch #(.W(DATA_W), .HAS_BSR(1'b0)) u_lat_b (
      .clk (clk), .rst (rst), .clr (mode_ld), .ld (b_ld), .ld_data (bus_wdata),
      .bit_en (1'b0), .bit_idx ('0), .bit_val (1'b0), .q (b_q)
   );

   pio3_latch #(.W(DATA_W), .HAS_BSR(1'b1)) u_lat_c (
      .clk (clk), .rst (rst), .clr (mode_ld), .ld (c_ld), .ld_data (bus_wdata),
      .bit_en (bsr_en), .bit_idx (bsr_idx), .bit_val (bsr_val), .q (c_q)
   );

   assign a_dir = {DATA_W{cfg.a_in}};
   assign b_dir = {DATA_W{cfg.b_in}};
   assign c_dir = {{NIB_W{cfg.cu_in}}, {NIB_W{cfg.cl_in}}};

   pio3_rdsel #(.W(DATA_W)) u_rd_a (.dir_in (a_dir), .pin (pa_in), .lat (a_q), .dout (a_rd));
   pio3_rdsel #(.W(DATA_W)) u_rd_b (.dir_in (b_dir), .pin (pb_in), .lat (b_q), .dout (b_rd));
   pio3_rdsel #(.W(DATA_W)) u_rd_c (.dir_in (c_dir), .pin (pc_in), .lat (c_q), .dout (c_rd));

   always_comb begin
      unique case (sel)
         SEL_PA:  rd_mux = a_rd;
         SEL_PB:  rd_mux = b_rd;
         SEL_PC:  rd_mux = c_rd;
         default: rd_mux = CTRL_RD_VAL;
      endcase
   end

   assign bus_rdata    = rd_stb ? rd_mux : '0;
   assign bus_rdata_oe = rd_stb;

   assign pa_out = a_q;
   assign pb_out = b_q;
   assign pc_out = c_q;
   assign pa_oe  = ~a_dir;
   assign pb_oe  = ~b_dir;
   assign pc_oe  = ~c_dir;

   // R2
   ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_stb && sel == SEL_CTL) |-> (bus_rdata == CTRL_RD_VAL));

   // R3
   reset_state_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 &&
                      pa_out == '0 && pb_out == '0 && pc_out == '0));

endmodule

// File: tb/sim_pio3_port.sv
module sim_pio3_port;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 5;

   // {ctrl, wr A, wr B, wr C, pin A, pin B, pin C, exp A, exp B, exp C}
   localparam logic [79:0] VEC [NVEC] = '{
      {8'h82, 8'h5A, 8'h11, 8'hC3, 8'hFF, 8'h3C, 8'h00, 8'h5A, 8'h3C, 8'hC3},
      {8'h9B, 8'h12, 8'h34, 8'h56, 8'hA5, 8'h0F, 8'h96, 8'hA5, 8'h0F, 8'h96},
      {8'h88, 8'h77, 8'hE1, 8'h4B, 8'h00, 8'hFF, 8'hF0, 8'h77, 8'hE1, 8'hFB},
      {8'h81, 8'h01, 8'h80, 8'h2D, 8'hFE, 8'h7F, 8'h0A, 8'h01, 8'h80, 8'h2A},
      {8'hE4, 8'h3C, 8'hC3, 8'h99, 8'h00, 8'h00, 8'h66, 8'h3C, 8'hC3, 8'h99}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bus_sel = 1'b0;
   logic       bus_rd = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'b00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       bus_rdata_oe;
   logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
   logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   logic [7:0] rv;

   always #(CLK_PERIOD/2) clk = ~clk;

   pio3_port u0 (
      .clk (clk), .rst (rst), .bus_sel (bus_sel), .bus_rd (bus_rd), .bus_wr (bus_wr),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .bus_rdata_oe (bus_rdata_oe),
      .pa_in (pa_in), .pa_out (pa_out), .pa_oe (pa_oe),
      .pb_in (pb_in), .pb_out (pb_out), .pb_oe (pb_oe),
      .pc_in (pc_in), .pc_out (pc_out), .pc_oe (pc_oe)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input bit cs = 1'b1);
      @(negedge clk);
      bus_sel = cs; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
      #1;
      d = bus_rdata;
      check("R10 valid flag during read", {7'd0, bus_rdata_oe}, 8'h01);
      bus_sel = 1'b0; bus_rd = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      pa_in = 8'h6C; pb_in = 8'h93; pc_in = 8'h5E;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R3 reset state
      check("R3 pa_oe", pa_oe, 8'h00);
      check("R3 pb_oe", pb_oe, 8'h00);
      check("R3 pc_oe", pc_oe, 8'h00);
      check("R3 pc_out", pc_out, 8'h00);
      bus_read(2'd0, rv); check("R3 R1 read A pins", rv, 8'h6C);
      bus_read(2'd1, rv); check("R3 R1 read B pins", rv, 8'h93);
      bus_read(2'd2, rv); check("R3 R1 read C pins", rv, 8'h5E);
      // R2
      bus_read(2'd3, rv); check("R2 control read", rv, 8'hFF);

      // table walk: R4 R8 R9 R12
      for (int i = 0; i < NVEC; i++) begin
         logic [7:0] cw;
         cw = VEC[i][79:72];
         bus_write(2'd3, cw);
         bus_write(2'd0, VEC[i][71:64]);
         bus_write(2'd1, VEC[i][63:56]);
         bus_write(2'd2, VEC[i][55:48]);
         pa_in = VEC[i][47:40]; pb_in = VEC[i][39:32]; pc_in = VEC[i][31:24];
         bus_read(2'd0, rv); check("R9 R1 read A", rv, VEC[i][23:16]);
         bus_read(2'd1, rv); check("R9 R1 read B", rv, VEC[i][15:8]);
         bus_read(2'd2, rv); check("R9 R1 read C", rv, VEC[i][7:0]);
         check("R4 pa_oe", pa_oe, cw[4] ? 8'h00 : 8'hFF);
         check("R4 pb_oe", pb_oe, cw[1] ? 8'h00 : 8'hFF);
         check("R4 pc_oe", pc_oe, {cw[3] ? 4'h0 : 4'hF, cw[0] ? 4'h0 : 4'hF});
         check("R8 pa_out latch", pa_out, VEC[i][71:64]);
         if (i == 0) begin
            check("R12 0x82 A out", pa_oe, 8'hFF);
            check("R12 0x82 B in", pb_oe, 8'h00);
            check("R12 0x82 C out", pc_oe, 8'hFF);
         end
      end

      // R5 mode word clears latches
      check("R5 pre pb_out", pb_out, 8'hC3);
      bus_write(2'd3, 8'h80);
      check("R5 pa_out", pa_out, 8'h00);
      check("R5 pb_out", pb_out, 8'h00);
      check("R5 pc_out", pc_out, 8'h00);

      // R6 single bit changes
      bus_write(2'd3, 8'h07); check("R6 set bit3", pc_out, 8'h08);
      bus_write(2'd3, 8'h7F); check("R6 set bit7 ignore 6:4", pc_out, 8'h88);
      bus_write(2'd3, 8'h06); check("R6 clear bit3", pc_out, 8'h80);
      bus_write(2'd3, 8'h0F); check("R6 repeat bit7", pc_out, 8'h80);
      bus_write(2'd3, 8'h01); check("R6 set bit0", pc_out, 8'h81);
      // R7
      check("R7 pc_oe kept", pc_oe, 8'hFF);
      check("R7 pa_oe kept", pa_oe, 8'hFF);
      bus_write(2'd3, 8'h89);
      bus_write(2'd3, 8'h0D);
      check("R7 pc_oe inputs kept", pc_oe, 8'h00);
      check("R7 pa_oe outputs kept", pa_oe, 8'hFF);

      // R8 latch loads while input
      bus_write(2'd3, 8'h90);
      bus_write(2'd0, 8'h3E);
      check("R8 latch while input", pa_out, 8'h3E);
      check("R8 no drive while input", pa_oe, 8'h00);

      // R10 no read data without select
      @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b1; bus_addr = 2'd3;
      #1;
      check("R10 rdata idle", bus_rdata, 8'h00);
      check("R10 valid idle", {7'd0, bus_rdata_oe}, 8'h00);
      bus_rd = 1'b0;

      // R11 write timing and select gating
      bus_write(2'd3, 8'h80);
      bus_write(2'd1, 8'h55, 1'b0);
      check("R11 unselected write", pb_out, 8'h00);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'hA7;
      #1;
      check("R11 before edge", pb_out, 8'h00);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      check("R11 after edge", pb_out, 8'hA7);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule